// File: doc/BRIEF.md
# Transmit Symbol Path with Loopback Bypass and Disparity Control

This block sits on the transmit side of a serial PHY. Each clock cycle it takes two MAC bytes, each with its own control flag, and turns them into two 10-bit line symbols with an 8b/10b encoder. The encoder keeps track of running disparity (RD). RD passes from the low byte to the high byte inside a cycle and then on to the next cycle. The two symbols are registered and handed to the serializer, with the low byte's symbol sent first.

Two further paths share the same output register:
- **Loopback.** When the MAC asks for loopback while electrical idle is not requested, the raw 10-bit symbols recovered by the receiver are copied to the output unchanged, without passing through the encoder. The receive decoder is outside this block, so received data still reaches the MAC while loopback is active.
- **Electrical idle.** An electrical-idle request drives a fixed idle pattern and freezes RD. Before asking for idle, the MAC is expected to have sent a comma (K28.5) and then K28.3 idle symbols.

A one-cycle compliance strobe makes the encoder start that cycle's word from negative RD. Every change of source happens on a whole-cycle boundary.

Top module: `phy_tx_lpbk_top`

## Requirements
- R1: While reset is held, the output is the idle value (all zero by default). RD resets to negative, so the first encoded low symbol after reset uses the RD- column.
- R2: Each byte is encoded as standard 8b/10b. Byte b of `tx_data_i` is bits [8b+7:8b] and maps to `tx_sym_o[10b+9:10b]`; `tx_k_i[b]` set selects a control code. Symbols are laid out {a,b,c,d,e,i,f,g,h,j} with a in bit 9. Reference codes: K28.5 is 0011111010 (RD-) and 1100000101 (RD+); D21.5 is 1010101010; D10.2 is 0101010101; D0.0 from RD- is 1001110100.
- R3: RD passes from the low symbol to the high symbol, then to the next encoded cycle. A symbol encoded from RD- has 5 or 6 ones, and one from RD+ has 4 or 5. A 6-one symbol leaves RD positive and a 4-one symbol leaves it negative.
- R4: When `tx_compl_i` is high in an encoded cycle, that cycle's low symbol is encoded from RD- whatever RD was before.
- R5: Inputs sampled at clock edge N are reflected on `tx_sym_o` right after edge N (one register stage).
- R6: With electrical idle requested and loopback not active, both symbols are the idle value and RD is left unchanged.
- R7: Loopback begins only in a cycle where the loopback request is high and the electrical-idle request is low. With both requests high from outside loopback, the output is idle.
- R8: While loopback is active, `rx_sym_i` is copied to `tx_sym_o` bit for bit. RD is left unchanged, and the electrical-idle request and compliance strobe have no effect.
- R9: Dropping the loopback request ends loopback in that same cycle. The output then shows encoded MAC data, or idle if electrical idle is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data_i | input | 16 | MAC transmit bytes, low byte sent first |
| tx_k_i | input | 2 | Per-byte control-code flag |
| tx_lpbk_req_i | input | 1 | Loopback request |
| tx_eidle_req_i | input | 1 | Electrical-idle request |
| tx_compl_i | input | 1 | One-cycle strobe forcing RD- for this word |
| rx_sym_i | input | 20 | Raw received 10-bit symbols, low symbol in [9:0] |
| tx_sym_o | output | 20 | Symbols to the serializer, low symbol in [9:0] |

## Verification
A wrong RD bit shows up in the first encoded cycle after it goes wrong. A comma or unbalanced code then comes out in the wrong column, and the ones count of the symbol breaks the 5/6-versus-4/5 rule. A wrong mode shows one cycle after the inputs that caused it: the output carries the wrong source (encoder, received symbols or idle). An RD value damaged during idle or loopback shows on the first comma sent afterwards.

// File: rtl/phy_tx_pkg.sv
package phy_tx_pkg;

  localparam int SYM_W = 10;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_NORM = 2'd1,
    MODE_LPBK = 2'd2
  } tx_mode_e;

  typedef struct packed {
    logic [SYM_W-1:0] sym;
    logic             rd;   // 1 = positive after this symbol
  } enc_res_t;

  // 5b/6b sub-block, RD- column, bits abcdei
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  // 3b/4b sub-block, RD- column, bits fghj (primary .7)
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;  3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;  3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;  3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;  default: four_neg = 4'b1110;
    endcase
  endfunction

  function automatic logic [2:0] ones6(input logic [5:0] v);
    ones6 = 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]) + 3'(v[4]) + 3'(v[5]);
  endfunction

  function automatic logic [2:0] ones4(input logic [3:0] v);
    ones4 = 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction

  // Full byte encode: rd_in 1 = positive
  function automatic enc_res_t enc_byte(input logic [7:0] d, input logic k,
                                        input logic rd_in);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s6;
    logic [3:0] s4;
    logic       k28, unbal6, unbal4, rd6, alt;
    enc_res_t   r;
    x      = d[4:0];
    y      = d[7:5];
    k28    = k && (x == 5'd28);
    s6     = k28 ? 6'b001111 : six_neg(x);
    unbal6 = (ones6(s6) != 3'd3);
    if (rd_in && (unbal6 || x == 5'd7)) s6 = ~s6;
    rd6    = unbal6 ? ~rd_in : rd_in;
    alt    = (y == 3'd7) &&
             (k || (!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                   ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    s4     = alt ? 4'b0111 : four_neg(y);
    unbal4 = (ones4(s4) != 3'd2);
    if (rd6 && (unbal4 || y == 3'd3)) s4 = ~s4;
    if (k28 && !rd6 && !unbal4 && y != 3'd3) s4 = ~s4;
    r.sym = {s6, s4};
    r.rd  = unbal4 ? ~rd6 : rd6;
    return r;
  endfunction

endpackage

// File: rtl/phy_tx_byte_enc.sv
module phy_tx_byte_enc
  import phy_tx_pkg::*;
(
  input  logic [7:0]       data_i,
  input  logic             k_i,
  input  logic             rd_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             rd_o
);

  enc_res_t res;

  always_comb begin
    res   = enc_byte(data_i, k_i, rd_i);
    sym_o = res.sym;
    rd_o  = res.rd;
  end

endmodule

// File: rtl/phy_tx_mode_ctl.sv
module phy_tx_mode_ctl
  import phy_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lpbk_req_i,
  input  logic     eidle_req_i,
  output tx_mode_e mode_nxt_o
);

  tx_mode_e mode_q;
  tx_mode_e mode_nxt;

  always_comb begin
    if (mode_q == MODE_LPBK && lpbk_req_i)
      mode_nxt = MODE_LPBK;
    else if (lpbk_req_i && !eidle_req_i)
      mode_nxt = MODE_LPBK;
    else if (eidle_req_i)
      mode_nxt = MODE_IDLE;
    else
      mode_nxt = MODE_NORM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_nxt;
  end

  assign mode_nxt_o = mode_nxt;

endmodule

// File: rtl/phy_tx_lpbk_top.sv
module phy_tx_lpbk_top
  import phy_tx_pkg::*;
#(
  parameter int         BYTES    = 2,
  parameter logic [9:0] IDLE_SYM = 10'b0
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*BYTES-1:0]   tx_data_i,
  input  logic [BYTES-1:0]     tx_k_i,
  input  logic                 tx_lpbk_req_i,
  input  logic                 tx_eidle_req_i,
  input  logic                 tx_compl_i,
  input  logic [10*BYTES-1:0]  rx_sym_i,
  output logic [10*BYTES-1:0]  tx_sym_o
);

  localparam int SW = SYM_W * BYTES;

  tx_mode_e        mode_nxt;
  logic            norm_sel;
  logic            lpbk_sel;
  logic            rd_q;
  logic            rd_seed;
  logic [BYTES:0]  rd_chain;
  logic [SW-1:0]   enc_sym;
  logic [SW-1:0]   sym_nxt;
  logic [SW-1:0]   sym_q;

  phy_tx_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .lpbk_req_i  (tx_lpbk_req_i),
    .eidle_req_i (tx_eidle_req_i),
    .mode_nxt_o  (mode_nxt)
  );

  assign norm_sel    = (mode_nxt == MODE_NORM);
  assign lpbk_sel    = (mode_nxt == MODE_LPBK);
  assign rd_seed     = tx_compl_i ? 1'b0 : rd_q;
  assign rd_chain[0] = rd_seed;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    phy_tx_byte_enc u_enc (
      .data_i (tx_data_i[8*g +: 8]),
      .k_i    (tx_k_i[g]),
      .rd_i   (rd_chain[g]),
      .sym_o  (enc_sym[SYM_W*g +: SYM_W]),
      .rd_o   (rd_chain[g+1])
    );
  end

  always_comb begin
    case (mode_nxt)
      MODE_NORM: sym_nxt = enc_sym;
      MODE_LPBK: sym_nxt = rx_sym_i;
      default:   sym_nxt = {BYTES{IDLE_SYM}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_q <= {BYTES{IDLE_SYM}};
      rd_q  <= 1'b0;
    end else begin
      sym_q <= sym_nxt;
      if (norm_sel) rd_q <= rd_chain[BYTES];
    end
  end

  assign tx_sym_o = sym_q;

endmodule

// File: rtl/phy_tx_lpbk_chk.sv
module phy_tx_lpbk_chk
  import phy_tx_pkg::*;
#(
  parameter int         BYTES    = 2,
  parameter logic [9:0] IDLE_SYM = 10'b0
)(
  input logic                clk,
  input logic                rst_n,
  input logic                tx_lpbk_req_i,
  input logic                tx_eidle_req_i,
  input logic                tx_compl_i,
  input logic [10*BYTES-1:0] rx_sym_i,
  input logic [10*BYTES-1:0] tx_sym_o,
  input logic                norm_sel,
  input logic                lpbk_sel,
  input logic                rd_q
);

  for (genvar g = 0; g < BYTES; g++) begin : g_w
    a_r3_sym_weight: assert property (@(posedge clk) disable iff (!rst_n)
      norm_sel |=> ($countones(tx_sym_o[10*g +: 10]) >= 4 &&
                    $countones(tx_sym_o[10*g +: 10]) <= 6));
  end

  a_r4_compl_neg_start: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_sel && tx_compl_i) |=> $countones(tx_sym_o[9:0]) >= 5);

  a_r6_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!norm_sel && !lpbk_sel) |=> tx_sym_o == {BYTES{IDLE_SYM}});

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_sel |=> $stable(rd_q));

  a_r7_entry_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpbk_sel) |-> !tx_eidle_req_i);

  a_r8_lpbk_raw: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_sel |=> tx_sym_o == $past(rx_sym_i));

  a_r9_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_lpbk_req_i |-> !lpbk_sel);

endmodule

bind phy_tx_lpbk_top phy_tx_lpbk_chk #(.BYTES(BYTES), .IDLE_SYM(IDLE_SYM)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_lpbk_req_i  (tx_lpbk_req_i),
  .tx_eidle_req_i (tx_eidle_req_i),
  .tx_compl_i     (tx_compl_i),
  .rx_sym_i       (rx_sym_i),
  .tx_sym_o       (tx_sym_o),
  .norm_sel       (norm_sel),
  .lpbk_sel       (lpbk_sel),
  .rd_q           (rd_q)
);

// File: tb/tb_phy_tx_lpbk_top.sv
`timescale 1ns/1ps
module tb_phy_tx_lpbk_top;

  localparam logic [9:0] K285N = 10'b0011111010;
  localparam logic [9:0] K285P = 10'b1100000101;
  localparam logic [9:0] D215  = 10'b1010101010;
  localparam logic [9:0] D102  = 10'b0101010101;
  localparam logic [9:0] D000N = 10'b1001110100;
  localparam logic [7:0] B_K285 = 8'hBC;
  localparam logic [7:0] B_D215 = 8'hB5;
  localparam logic [7:0] B_D102 = 8'h4A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_data = '0;
  logic [1:0]  tx_k = '0;
  logic        lpbk = 1'b0;
  logic        eidle = 1'b0;
  logic        compl = 1'b0;
  logic [19:0] rx_sym = '0;
  logic [19:0] tx_sym;

  int n_vec = 0;
  int n_bad = 0;
  logic b_rd = 1'b0;   // bench view of running disparity, 1 = positive
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  phy_tx_lpbk_top dut (
    .clk(clk), .rst_n(rst_n), .tx_data_i(tx_data), .tx_k_i(tx_k),
    .tx_lpbk_req_i(lpbk), .tx_eidle_req_i(eidle), .tx_compl_i(compl),
    .rx_sym_i(rx_sym), .tx_sym_o(tx_sym)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive one cycle; returns after the capturing edge
  task automatic cyc(input logic [15:0] d, input logic [1:0] k, input logic lp,
                     input logic ei, input logic cp, input logic [19:0] rx);
    @(negedge clk);
    tx_data = d; tx_k = k; lpbk = lp; eidle = ei; compl = cp; rx_sym = rx;
    @(posedge clk);
    #1;
  endtask

  // disparity monitor for an encoded cycle (R3, R4)
  task automatic mon(input logic cp);
    if (cp) b_rd = 1'b0;
    for (int b = 0; b < 2; b++) begin
      int c;
      logic ok;
      c = $countones(tx_sym[10*b +: 10]);
      ok = b_rd ? (c == 4 || c == 5) : (c == 5 || c == 6);
      n_vec++;
      if (!ok) begin
        n_bad++;
        $display("FAIL R3 lane%0d ones act=%0d exp=%s", b, c, b_rd ? "4|5" : "5|6");
      end
      if (c == 6) b_rd = 1'b1;
      if (c == 4) b_rd = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset output", tx_sym, 20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    b_rd = 1'b0;
    cyc({B_K285, B_K285}, 2'b11, 0, 0, 0, '0);
    chk("R1 first word from RD-", tx_sym, {K285P, K285N});
    mon(0);
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 0, '0);
    chk("R3 rd carried across cycle", tx_sym, {D215, K285N});
    mon(0);
  endtask

  task automatic t_codes;
    cyc({B_K285, B_D215}, 2'b10, 0, 0, 0, '0);
    chk("R2 K28.5 RD+ high lane", tx_sym, {K285P, D215});
    mon(0);
    cyc({B_D102, 8'h00}, 2'b00, 0, 0, 0, '0);
    chk("R2 D0.0 RD- and D10.2", tx_sym, {D102, D000N});
    mon(0);
  endtask

  task automatic t_compl;
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 0, '0);
    chk("R3 setup to RD+", tx_sym, {D215, K285N});
    mon(0);
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 1, '0);
    chk("R4 compliance forces RD-", tx_sym, {D215, K285N});
    mon(1);
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 0, '0);
    chk("R4 rd continues after strobe", tx_sym, {D215, K285P});
    mon(0);
  endtask

  task automatic t_eidle;
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 0, '0);
    chk("R3 setup to RD+", tx_sym, {D215, K285N});
    mon(0);
    for (int i = 0; i < 3; i++) begin
      cyc(16'h1234 + 16'(i), 2'b00, 0, 1, i == 1, 20'hFFFFF);
      chk("R6 idle output", tx_sym, 20'h0);
    end
    cyc(16'h5555, 2'b00, 1, 1, 0, 20'h12345);
    chk("R7 no entry while idle requested", tx_sym, 20'h0);
    cyc({B_D215, B_K285}, 2'b01, 0, 0, 0, '0);
    chk("R6 rd preserved across idle", tx_sym, {D215, K285P});
    mon(0);
  endtask

  task automatic t_lpbk;
    cyc(16'hFFFF, 2'b11, 1, 0, 0, 20'hABCDE);
    chk("R5 R8 loopback one cycle latency", tx_sym, 20'hABCDE);
    cyc(16'h0000, 2'b00, 1, 1, 1, 20'h13579);
    chk("R8 idle and compliance ignored", tx_sym, 20'h13579);
    cyc(16'h0000, 2'b00, 1, 0, 0, 20'h0F0F0);
    chk("R8 raw copy", tx_sym, 20'h0F0F0);
    cyc({B_K285, B_K285}, 2'b11, 0, 0, 0, 20'hFFFFF);
    chk("R9 exit to encoded data, rd kept", tx_sym, {K285P, K285N});
    mon(0);
    cyc(16'h0, 2'b00, 1, 0, 0, 20'h55AA5);
    chk("R8 re-entry", tx_sym, 20'h55AA5);
    cyc(16'h0, 2'b00, 0, 1, 0, 20'h55AA5);
    chk("R9 exit to idle", tx_sym, 20'h0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic cp;
      logic [1:0] kk;
      logic [15:0] dd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cp = (lfsr[3:0] == 4'h5);
      dd = lfsr;
      kk = 2'b00;
      if (lfsr[9:7] == 3'b111) begin dd[7:0] = B_K285; kk[0] = 1'b1; end
      cyc(dd, kk, 0, 0, cp, '0);
      mon(cp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_codes();
    t_compl();
    t_eidle();
    t_lpbk();
    t_random();
    finish_run();
  end

endmodule